// File: doc/BRIEF.md
# Engine Control and Error Status Unit

This block is the register front end that a host uses to command a small vector rendering engine. A host port carries 32-bit words. It can start and stop the engine and enable page-bound checking. It can arm six error classes for interrupts and load the page bounds, the plane mask and the raster-op code that the execution units consume. It also reads an identification word and a count of instruction-queue overflows.

Errors reported by the execution units are latched as sticky flags. The host clears a flag by writing 1 to it. A flag raises the single interrupt line only when the enable for its class and the global interrupt enable are both set.

The block also decodes writes into the 128-entry register file. One address window writes an entry directly, and only while the engine is stopped. A second window turns the write into a register-write pseudo-instruction that is pushed into the instruction queue. The queue and the execution units sit outside the block.

Top module: `engine_ctl_regs`

## Requirements
- R1: After reset, `run`, `irq`, `rf_wr_en`, `q_push` and `host_rdata` are 0. All error flags, the overflow counter and the control fields read 0.
- R2: Control word at 0x00. Bits 5:0 are the error enables, bit 7 the interrupt enable, bit 12 page-bound checking (`pb_check_en`) and bit 14 run (`run`). These are writable and read back. Bit 15 reads the current `q_empty`. Bit 13 is set by an `eng_wrote` pulse and cleared by writing 1 to it; a set in the same cycle wins.
- R3: Error word at 0x04. Bit i (0 = illegal instruction, 1 = page bound, 2 = memory access, 3 = register access, 4 = alignment, 5 = queue write) is set by `eng_err[i]` and holds until the host writes 1 to that bit. A set and a clear in the same cycle leave the flag set.
- R4: A write to 0x100 + 4·r with r in 0..127, made while `run` is 0, pulses `rf_wr_en` in the next cycle with `rf_wr_idx` = r and `rf_wr_data` = the write data. The same write while `run` is 1 is dropped and sets error bit 3. An address whose low two bits are not 0 is ignored.
- R5: A write to 0x300 + 4·r pulses `q_push` in the next cycle with `q_push_idx` = r and `q_push_data` = the data, if `q_full` is 0. If `q_full` is 1, nothing is pushed, the counter at 0x18 increments and error bit 5 sets.
- R6: `irq` is registered. It is 1 one cycle after any error flag is set together with its enable bit while interrupt enable (bit 7 of the control word) is 1. Bit 7 of the error word reads `irq`.
- R7: A write of any value to 0x30 clears `run`, all error flags and the overflow counter. It leaves the enables and the other registers unchanged.
- R8: The ID word at 0x28 reads the architecture code (default 0x01) in bits 7:0 and the chip revision (default 0x02) in bits 15:8. All other bits are 0.
- R9: Lower bound 0x08, upper bound 0x0C and plane mask 0x10 are full 32-bit registers driven on `page_lo`, `page_hi` and `plane_mask`. The raster-op code at 0x14 keeps data bits 7:0, drives `rop_code` and reads back zero-extended.
- R10: `host_rdata` is registered. It presents the addressed word in the cycle after `host_rd`, using the state before that edge, and reads 0 in cycles without a read. Unmapped offsets, for example 0x1C and 0x24, read 0.
- R11: The overflow counter saturates at its maximum value (255 for the default 8-bit width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 12 | Byte offset |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |
| eng_err | input | 6 | Error event pulses from the execution units |
| eng_wrote | input | 1 | Pulse: the engine performed a memory write |
| q_empty | input | 1 | Instruction queue is empty |
| q_full | input | 1 | Instruction queue is full |
| run | output | 1 | Engine run bit |
| pb_check_en | output | 1 | Page-bound checking enable |
| page_lo | output | 32 | Lower page bound |
| page_hi | output | 32 | Upper page bound |
| plane_mask | output | 32 | Plane mask |
| rop_code | output | 8 | Raster-op code |
| rf_wr_en | output | 1 | Direct register-file write strobe |
| rf_wr_idx | output | 7 | Direct write entry index |
| rf_wr_data | output | 32 | Direct write data |
| q_push | output | 1 | Queue push of a register-write pseudo-instruction |
| q_push_idx | output | 7 | Target entry of the queued write |
| q_push_data | output | 32 | Data of the queued write |
| irq | output | 1 | Error interrupt |

## Verification
The bound checker watches four properties on every cycle:
- a direct write strobe never follows a cycle in which the engine was running;
- no push is issued after a full-queue cycle;
- the interrupt never rises without a latched flag;
- flags stay set, and the overflow count never falls, unless a clear or soft reset occurred.

Only the bench's scenarios can show the rest:
- the exact field positions and readback values;
- set-over-clear priority in a shared cycle;
- per-class and global interrupt gating;
- counter saturation;
- soft-reset scope.

The bench shows these by comparing the block against a behavioural model on every clock.

// File: rtl/engine_ctl_pkg.sv
package engine_ctl_pkg;
  localparam int N_ERR = 6;

  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_ERR   = 'h04;
  localparam int OFF_PBLO  = 'h08;
  localparam int OFF_PBHI  = 'h0C;
  localparam int OFF_PMASK = 'h10;
  localparam int OFF_ROP   = 'h14;
  localparam int OFF_OVF   = 'h18;
  localparam int OFF_ID    = 'h28;
  localparam int OFF_SRST  = 'h30;
  localparam int DIR_BASE  = 'h100;
  localparam int Q_BASE    = 'h300;

  // control word bit positions
  localparam int CB_IE  = 7;
  localparam int CB_PB  = 12;
  localparam int CB_WO  = 13;
  localparam int CB_RUN = 14;
  localparam int CB_MT  = 15;

  // error classes, bit order is decoded by software
  localparam int EB_REG  = 3;
  localparam int EB_QWR  = 5;
  localparam int EB_IRQ  = 7;

  typedef enum logic [3:0] {
    K_NONE, K_CTRL, K_ERR, K_PBLO, K_PBHI, K_PMASK,
    K_ROP, K_OVF, K_ID, K_SRST, K_RF_DIR, K_RF_Q
  } reg_kind_e;
endpackage

// File: rtl/ecs_addr_decode.sv
module ecs_addr_decode
  import engine_ctl_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int RF_DEPTH = 128,
  localparam int IDX_W   = $clog2(RF_DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] DIR_LO = ADDR_W'(DIR_BASE);
  localparam logic [ADDR_W-1:0] DIR_HI = ADDR_W'(DIR_BASE + 4 * RF_DEPTH);
  localparam logic [ADDR_W-1:0] Q_LO   = ADDR_W'(Q_BASE);
  localparam logic [ADDR_W-1:0] Q_HI   = ADDR_W'(Q_BASE + 4 * RF_DEPTH);

  logic in_dir, in_q, aligned;

  assign aligned = (addr[1:0] == 2'b00);
  assign in_dir  = aligned && (addr >= DIR_LO) && (addr < DIR_HI);
  assign in_q    = aligned && (addr >= Q_LO) && (addr < Q_HI);

  always_comb begin
    idx = '0;
    if (in_dir)    idx = IDX_W'((addr - DIR_LO) >> 2);
    else if (in_q) idx = IDX_W'((addr - Q_LO) >> 2);
  end

  always_comb begin
    kind = K_NONE;
    if (in_dir)                              kind = K_RF_DIR;
    else if (in_q)                           kind = K_RF_Q;
    else if (addr == ADDR_W'(OFF_CTRL))      kind = K_CTRL;
    else if (addr == ADDR_W'(OFF_ERR))       kind = K_ERR;
    else if (addr == ADDR_W'(OFF_PBLO))      kind = K_PBLO;
    else if (addr == ADDR_W'(OFF_PBHI))      kind = K_PBHI;
    else if (addr == ADDR_W'(OFF_PMASK))     kind = K_PMASK;
    else if (addr == ADDR_W'(OFF_ROP))       kind = K_ROP;
    else if (addr == ADDR_W'(OFF_OVF))       kind = K_OVF;
    else if (addr == ADDR_W'(OFF_ID))        kind = K_ID;
    else if (addr == ADDR_W'(OFF_SRST))      kind = K_SRST;
  end
endmodule

// File: rtl/ecs_err_unit.sv
module ecs_err_unit #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         srst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] en,
  input  logic         ie,
  output logic [N-1:0] flags,
  output logic         irq
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || srst)     flags[g] <= 1'b0;
      else if (set_vec[g]) flags[g] <= 1'b1;
      else if (clr_vec[g]) flags[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ie && |(flags & en);
  end
endmodule

// File: rtl/ecs_sat_counter.sv
module ecs_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)               cnt <= '0;
    else if (inc && (cnt != '1))  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/engine_ctl_regs.sv
module engine_ctl_regs
  import engine_ctl_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter int          RF_DEPTH  = 128,
  parameter int          CNT_W     = 8,
  parameter logic [7:0]  ARCH_CODE = 8'h01,
  parameter logic [7:0]  CHIP_REV  = 8'h02,
  localparam int         IDX_W     = $clog2(RF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [N_ERR-1:0]  eng_err,
  input  logic              eng_wrote,
  input  logic              q_empty,
  input  logic              q_full,
  output logic              run,
  output logic              pb_check_en,
  output logic [DATA_W-1:0] page_lo,
  output logic [DATA_W-1:0] page_hi,
  output logic [DATA_W-1:0] plane_mask,
  output logic [7:0]        rop_code,
  output logic              rf_wr_en,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              q_push,
  output logic [IDX_W-1:0]  q_push_idx,
  output logic [DATA_W-1:0] q_push_data,
  output logic              irq
);
  reg_kind_e          kind;
  logic [IDX_W-1:0]   idx;
  logic [N_ERR-1:0]   err_en, err_flags, err_set, err_clr;
  logic               irq_en, wrote;
  logic               soft_hit, err_clr_any, dir_viol, q_ovf;
  logic [CNT_W-1:0]   ovf_cnt;
  logic [DATA_W-1:0]  rd_mux;
  logic [15:0]        ctrl_word;

  ecs_addr_decode #(.ADDR_W(ADDR_W), .RF_DEPTH(RF_DEPTH)) u_dec (
    .addr(host_addr), .kind(kind), .idx(idx)
  );

  assign soft_hit    = host_wr && (kind == K_SRST);
  assign dir_viol    = host_wr && (kind == K_RF_DIR) && run;
  assign q_ovf       = host_wr && (kind == K_RF_Q) && q_full;
  assign err_clr     = (host_wr && (kind == K_ERR)) ? host_wdata[N_ERR-1:0] : '0;
  assign err_clr_any = |err_clr;

  always_comb begin
    err_set         = eng_err;
    err_set[EB_REG] = eng_err[EB_REG] | dir_viol;
    err_set[EB_QWR] = eng_err[EB_QWR] | q_ovf;
  end

  ecs_err_unit #(.N(N_ERR)) u_err (
    .clk(clk), .rst(rst), .srst(soft_hit), .set_vec(err_set), .clr_vec(err_clr),
    .en(err_en), .ie(irq_en), .flags(err_flags), .irq(irq)
  );

  ecs_sat_counter #(.W(CNT_W)) u_ovf (
    .clk(clk), .rst(rst), .clr(soft_hit), .inc(q_ovf), .cnt(ovf_cnt)
  );

  // control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; pb_check_en <= 1'b0; irq_en <= 1'b0; err_en <= '0;
    end else if (soft_hit) begin
      run <= 1'b0;
    end else if (host_wr && kind == K_CTRL) begin
      run         <= host_wdata[CB_RUN];
      pb_check_en <= host_wdata[CB_PB];
      irq_en      <= host_wdata[CB_IE];
      err_en      <= host_wdata[N_ERR-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                             wrote <= 1'b0;
    else if (eng_wrote)                                  wrote <= 1'b1;
    else if (host_wr && kind == K_CTRL && host_wdata[CB_WO]) wrote <= 1'b0;
  end

  // parameter registers for the execution units
  always_ff @(posedge clk) begin
    if (rst) begin
      page_lo <= '0; page_hi <= '0; plane_mask <= '0; rop_code <= '0;
    end else if (host_wr) begin
      case (kind)
        K_PBLO:  page_lo    <= host_wdata;
        K_PBHI:  page_hi    <= host_wdata;
        K_PMASK: plane_mask <= host_wdata;
        K_ROP:   rop_code   <= host_wdata[7:0];
        default: ;
      endcase
    end
  end

  // register-file write paths
  always_ff @(posedge clk) begin
    if (rst) begin
      rf_wr_en <= 1'b0; q_push <= 1'b0;
      rf_wr_idx <= '0; rf_wr_data <= '0; q_push_idx <= '0; q_push_data <= '0;
    end else begin
      rf_wr_en <= host_wr && (kind == K_RF_DIR) && !run;
      q_push   <= host_wr && (kind == K_RF_Q) && !q_full;
      if (host_wr && kind == K_RF_DIR) begin
        rf_wr_idx  <= idx;
        rf_wr_data <= host_wdata;
      end
      if (host_wr && kind == K_RF_Q) begin
        q_push_idx  <= idx;
        q_push_data <= host_wdata;
      end
    end
  end

  // readback
  always_comb begin
    ctrl_word              = '0;
    ctrl_word[N_ERR-1:0]   = err_en;
    ctrl_word[CB_IE]       = irq_en;
    ctrl_word[CB_PB]       = pb_check_en;
    ctrl_word[CB_WO]       = wrote;
    ctrl_word[CB_RUN]      = run;
    ctrl_word[CB_MT]       = q_empty;
  end

  always_comb begin
    rd_mux = '0;
    case (kind)
      K_CTRL:  rd_mux = DATA_W'(ctrl_word);
      K_ERR:   rd_mux = DATA_W'({irq, 1'b0, err_flags});
      K_PBLO:  rd_mux = page_lo;
      K_PBHI:  rd_mux = page_hi;
      K_PMASK: rd_mux = plane_mask;
      K_ROP:   rd_mux = DATA_W'(rop_code);
      K_OVF:   rd_mux = DATA_W'(ovf_cnt);
      K_ID:    rd_mux = DATA_W'({CHIP_REV, ARCH_CODE});
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
    else              host_rdata <= '0;
  end
endmodule

// File: rtl/ecs_chk.sv
module ecs_chk #(
  parameter int N     = 6,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             irq,
  input logic             rf_wr_en,
  input logic             q_push,
  input logic             q_full,
  input logic [N-1:0]     flags,
  input logic [CNT_W-1:0] ovf_cnt,
  input logic             soft_hit,
  input logic             err_clr_any
);
  // R4
  dir_while_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> !$past(run));

  // R5
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    q_push |-> !$past(q_full));

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(flags) != '0));

  // R3
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!soft_hit && !err_clr_any) |=> ((flags & $past(flags)) == $past(flags)));

  // R11
  ovf_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !soft_hit |=> (ovf_cnt >= $past(ovf_cnt)));
endmodule

bind engine_ctl_regs ecs_chk #(.N(engine_ctl_pkg::N_ERR), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .irq(irq), .rf_wr_en(rf_wr_en),
  .q_push(q_push), .q_full(q_full), .flags(err_flags), .ovf_cnt(ovf_cnt),
  .soft_hit(soft_hit), .err_clr_any(err_clr_any)
);

// File: tb/tb_engine_ctl_regs.sv
module tb_engine_ctl_regs;
  logic        clk = 0, rst = 1;
  logic        host_wr = 0, host_rd = 0;
  logic [11:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic [5:0]  eng_err = 0;
  logic        eng_wrote = 0, q_empty = 1, q_full = 0;
  logic        run, pb_check_en, rf_wr_en, q_push, irq;
  logic [31:0] page_lo, page_hi, plane_mask, rf_wr_data, q_push_data;
  logic [7:0]  rop_code;
  logic [6:0]  rf_wr_idx, q_push_idx;

  int checks = 0, errors = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;  // 50 MHz

  engine_ctl_regs dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .eng_err(eng_err),
    .eng_wrote(eng_wrote), .q_empty(q_empty), .q_full(q_full), .run(run),
    .pb_check_en(pb_check_en), .page_lo(page_lo), .page_hi(page_hi),
    .plane_mask(plane_mask), .rop_code(rop_code), .rf_wr_en(rf_wr_en),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .q_push(q_push),
    .q_push_idx(q_push_idx), .q_push_data(q_push_data), .irq(irq)
  );

  // behavioural reference model
  logic        m_go, m_ie, m_pb, m_wo, m_irq, m_rfen, m_qp;
  logic [5:0]  m_en, m_flags;
  int          m_cnt;
  logic [31:0] m_plo, m_phi, m_pm, m_rfdat, m_qdat, m_rdata;
  logic [7:0]  m_rop;
  int          m_rfidx, m_qidx;

  function automatic logic [31:0] mread(int a);
    case (a)
      'h00: return {16'h0, q_empty, m_go, m_wo, m_pb, 4'h0, m_ie, 1'b0, m_en};
      'h04: return {24'h0, m_irq, 1'b0, m_flags};
      'h08: return m_plo;
      'h0C: return m_phi;
      'h10: return m_pm;
      'h14: return {24'h0, m_rop};
      'h18: return 32'(m_cnt);
      'h28: return 32'h0000_0201;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    int a;
    logic [31:0] rdv;
    logic n_irq, is_dir, is_q;
    logic [5:0] setv, clrv;
    a = int'(host_addr);
    if (rst) begin
      m_go = 0; m_ie = 0; m_pb = 0; m_wo = 0; m_irq = 0; m_rfen = 0; m_qp = 0;
      m_en = 0; m_flags = 0; m_cnt = 0; m_plo = 0; m_phi = 0; m_pm = 0;
      m_rop = 0; m_rdata = 0; m_rfidx = 0; m_qidx = 0; m_rfdat = 0; m_qdat = 0;
    end else begin
      rdv    = mread(a);
      n_irq  = m_ie && ((m_flags & m_en) != 0);
      is_dir = host_wr && a >= 'h100 && a < 'h300 && a % 4 == 0;
      is_q   = host_wr && a >= 'h300 && a < 'h500 && a % 4 == 0;
      m_rdata = host_rd ? rdv : 32'h0;
      m_rfen = is_dir && !m_go;
      m_qp   = is_q && !q_full;
      if (is_dir) begin m_rfidx = (a - 'h100) / 4; m_rfdat = host_wdata; end
      if (is_q)   begin m_qidx  = (a - 'h300) / 4; m_qdat  = host_wdata; end
      setv = eng_err;
      if (is_dir && m_go) setv[3] = 1;
      if (is_q && q_full) begin setv[5] = 1; if (m_cnt < 255) m_cnt++; end
      clrv = (host_wr && a == 'h04) ? host_wdata[5:0] : 6'h0;
      m_flags = (m_flags & ~clrv) | setv;
      if (eng_wrote) m_wo = 1;
      else if (host_wr && a == 0 && host_wdata[13]) m_wo = 0;
      if (host_wr) begin
        case (a)
          'h00: begin m_go = host_wdata[14]; m_pb = host_wdata[12];
                      m_ie = host_wdata[7]; m_en = host_wdata[5:0]; end
          'h08: m_plo = host_wdata;
          'h0C: m_phi = host_wdata;
          'h10: m_pm  = host_wdata;
          'h14: m_rop = host_wdata[7:0];
          'h30: begin m_go = 0; m_flags = 0; m_cnt = 0; end
          default: ;
        endcase
      end
      m_irq = n_irq;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      chk("R2", "run", 32'(run), 32'(m_go));
      chk("R2", "pb_check_en", 32'(pb_check_en), 32'(m_pb));
      chk("R6", "irq", 32'(irq), 32'(m_irq));
      chk("R4", "rf_wr_en", 32'(rf_wr_en), 32'(m_rfen));
      if (m_rfen) begin
        chk("R4", "rf_wr_idx", 32'(rf_wr_idx), 32'(m_rfidx));
        chk("R4", "rf_wr_data", rf_wr_data, m_rfdat);
      end
      chk("R5", "q_push", 32'(q_push), 32'(m_qp));
      if (m_qp) begin
        chk("R5", "q_push_idx", 32'(q_push_idx), 32'(m_qidx));
        chk("R5", "q_push_data", q_push_data, m_qdat);
      end
      chk("R9", "page_lo", page_lo, m_plo);
      chk("R9", "page_hi", page_hi, m_phi);
      chk("R9", "plane_mask", plane_mask, m_pm);
      chk("R9", "rop_code", 32'(rop_code), 32'(m_rop));
      chk(cur_tag, "host_rdata", host_rdata, m_rdata);
    end
  end

  task automatic wr(int a, logic [31:0] d);
    host_wr = 1; host_addr = 12'(a); host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(int a);
    host_rd = 1; host_addr = 12'(a);
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic evt(logic [5:0] m);
    eng_err = m;
    @(negedge clk);
    eng_err = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state seen at the ports
    chk("R1", "run after reset", 32'(run), 0);
    chk("R1", "irq after reset", 32'(irq), 0);
    chk("R1", "rf_wr_en after reset", 32'(rf_wr_en), 0);
    chk("R1", "q_push after reset", 32'(q_push), 0);
    chk("R1", "host_rdata after reset", host_rdata, 0);
    cur_tag = "R1"; rd('h00); rd('h04); rd('h18); idle(1);
    chk("R1", "ctrl readback", host_rdata, 32'h0);
    // R8
    cur_tag = "R8"; rd('h28); idle(1);
    // R10: unmapped and misaligned
    cur_tag = "R10"; rd('h1C); rd('h24); rd('h104); idle(1);
    cur_tag = "R4"; wr('h102, 32'hDEAD_0001); idle(2);
    // R9
    cur_tag = "R9";
    wr('h08, 32'h0000_1000); wr('h0C, 32'h0000_2000);
    wr('h10, 32'hFF00_FF00); wr('h14, 32'h0000_01A5);
    rd('h08); rd('h0C); rd('h10); rd('h14); idle(1);
    // R2: fields and queue-empty bit
    cur_tag = "R2";
    wr('h00, 32'h0000_10BF); rd('h00);
    q_empty = 0; rd('h00); q_empty = 1; idle(1);
    // R4: direct writes while stopped, incl. last entry
    cur_tag = "R4";
    wr('h114, 32'h1234_5678); wr('h2FC, 32'hCAFE_F00D); idle(1);
    cur_tag = "R2"; wr('h00, 32'h0000_50BF); rd('h00); idle(1);
    // R4 + R6: direct write while running is refused and interrupts
    cur_tag = "R4"; wr('h120, 32'h5555_AAAA); idle(2);
    cur_tag = "R6"; rd('h04); idle(1);
    // R3: write-one-to-clear
    cur_tag = "R3"; wr('h04, 32'h08); idle(2); rd('h04);
    evt(6'h15); rd('h04);
    eng_err = 6'h01; wr('h04, 32'h01); eng_err = 0; rd('h04);
    wr('h04, 32'h14); rd('h04); wr('h04, 32'h3F); idle(2);
    // R6: per-class and global gating
    cur_tag = "R6";
    wr('h00, 32'h0000_50BE); evt(6'h01); idle(2); rd('h04);
    evt(6'h02); idle(2); rd('h04);
    wr('h00, 32'h0000_503F); idle(2); rd('h04);
    wr('h04, 32'h3F); wr('h00, 32'h0000_50BF); idle(2);
    // R2: engine-wrote bit
    cur_tag = "R2";
    eng_wrote = 1; @(negedge clk); eng_wrote = 0; rd('h00);
    eng_wrote = 1; wr('h00, 32'h0000_70BF); eng_wrote = 0; rd('h00);
    wr('h00, 32'h0000_70BF); rd('h00); idle(1);
    // R5: queued writes
    cur_tag = "R5";
    wr('h324, 32'h0BAD_BEEF); wr('h4FC, 32'h7777_0000);
    q_full = 1; wr('h328, 32'h1111_2222); q_full = 0; idle(2);
    rd('h18); rd('h04); idle(1);
    // R11: saturation
    cur_tag = "R11";
    q_full = 1;
    for (int i = 0; i < 260; i++) wr('h300 + 4 * (i % 128), 32'(i));
    q_full = 0; idle(1); rd('h18); idle(1);
    // R7: soft reset
    cur_tag = "R7";
    wr('h30, 32'h0); idle(2);
    rd('h00); rd('h04); rd('h18); rd('h08); idle(2);
    chk("R7", "run after soft reset", 32'(run), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule